// File: doc/BRIEF.md
# Tournament Branch Predictor

This block predicts the direction of conditional branches by running two component predictors side by side and letting a per-branch chooser decide which one to believe. The global component is a table of 2-bit counters indexed by a shift register that holds the outcomes of the most recently resolved branches. The local component is a table of 2-bit counters indexed by the low-order bits of the branch address. A third table of 2-bit chooser counters is also indexed by low address bits. It learns, per branch, whether the global or the local component has been the more reliable one.

The fetch side is purely combinational. It presents an address and receives the final prediction, both component predictions, the chooser decision and the history value in use. The resolve side reports one branch per cycle with its address, its real outcome and the history value returned at fetch. Both component tables train on every report. The chooser moves only when the two components disagreed. The history register shifts in each reported outcome.

Top module: `tourney_bpred`

## Requirements
- R1: After reset every local and global counter holds 1 (weakly not taken), every chooser counter holds 1 (weakly local) and the history register holds 0. As a result `fetchTaken`, `fetchLocalPred`, `fetchGlobalPred`, `fetchUseGlobal` and `fetchHist` all read 0.
- R2: Each counter is 2 bits wide and saturates. A taken outcome raises it by one, up to a maximum of 3. A not-taken outcome lowers it by one, down to a minimum of 0. A counter value of 2 or 3 predicts taken.
- R3: The local counter used for an address is selected by the address bits `[LOC_IDX_W-1:0]`. Addresses that differ only above those bits share one entry.
- R4: The global counter is selected by the history register. Each accepted resolve shifts the history left and places the new outcome in bit 0, keeping `HIST_W` bits. The global counter trained on a resolve is the one at `updHist`.
- R5: The chooser entry for an address is selected by the address bits `[SEL_IDX_W-1:0]`. Values 0–1 choose the local prediction and values 2–3 choose the global prediction. `fetchTaken` equals the chosen component's prediction, and `fetchUseGlobal` is 1 when global is chosen.
- R6: On a resolve, the chooser entry rises by one (saturating) when only the global component was correct. It falls by one (saturating) when only the local component was correct. It is left unchanged when both components were correct or both were wrong.
- R7: Both component tables are trained on every accepted resolve, whichever component the chooser currently selects.
- R8: While `updValid` is 0, no counter and no history bit changes, whatever values the other resolve inputs carry.
- R9: The fetch outputs depend combinationally on `fetchPc` and the stored state. A resolve accepted at a clock edge becomes visible on the fetch outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchPc | input | PC_W | Address of the branch being predicted |
| fetchTaken | output | 1 | Final prediction, 1 = taken |
| fetchGlobalPred | output | 1 | Global component prediction |
| fetchLocalPred | output | 1 | Local component prediction |
| fetchUseGlobal | output | 1 | Chooser decision, 1 = global |
| fetchHist | output | HIST_W | History value used for this prediction |
| updValid | input | 1 | A resolved branch is reported this cycle |
| updPc | input | PC_W | Address of the resolved branch |
| updHist | input | HIST_W | History value returned with its prediction |
| updTaken | input | 1 | Real outcome, 1 = taken |

## Verification
The bench builds the block with 8-bit addresses and with 3-bit local index, chooser index and history. That gives eight entries per table, so it can sweep 16 fetch addresses after every resolve. Each sweep covers every table entry plus the aliasing of the upper address bit, and it is compared against an arithmetic model. Because the tables are so small, a few hundred resolves are enough to drive every counter through both saturation limits. The chooser is moved both ways by alternating patterns that favour the history-indexed component and by pseudo-random streams. Idle cycles with scrambled resolve inputs check that nothing moves.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT    = 2'd1;
  localparam ctr2_t CTR_WEAK_LOCAL = 2'd1;
  localparam ctr2_t CTR_MAX        = 2'd3;
  localparam ctr2_t CTR_MIN        = 2'd0;

  typedef struct packed {
    logic train;     // train both component tables and shift history
    logic dirTaken;  // resolved outcome
    logic selInc;    // move chooser toward global
    logic selDec;    // move chooser toward local
  } ctrlStrobes_t;

  function automatic ctr2_t satStep(input ctr2_t c, input logic up);
    if (up) return (c == CTR_MAX) ? c : c + 2'd1;
    else    return (c == CTR_MIN) ? c : c - 2'd1;
  endfunction

  function automatic logic ctrTaken(input ctr2_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/tbp_ctrl.sv
module tbp_ctrl
  import tbp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         updValid,
  input  logic         updTaken,
  input  logic         updGloPred,
  input  logic         updLocPred,
  output ctrlStrobes_t strobes
);

  logic gloRight;
  logic locRight;

  always_comb begin
    gloRight         = (updGloPred == updTaken);
    locRight         = (updLocPred == updTaken);
    strobes.train    = updValid;
    strobes.dirTaken = updTaken;
    strobes.selInc   = updValid && gloRight && !locRight;
    strobes.selDec   = updValid && locRight && !gloRight;
  end

  // R6: the chooser only moves when the components disagreed
  p_sel_needs_disagree_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.selInc || strobes.selDec) |-> (updGloPred != updLocPred));

  // R8: nothing is trained without a valid resolve
  p_idle_no_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> !(strobes.train || strobes.selInc || strobes.selDec));

endmodule

// File: rtl/tbp_datapath.sv
module tbp_datapath
  import tbp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int LOC_IDX_W = 8,
  parameter int HIST_W    = 8,
  parameter int SEL_IDX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic [PC_W-1:0]   updPc,
  input  logic [HIST_W-1:0] updHist,
  input  ctrlStrobes_t      strobes,
  output logic              fetchLocPred,
  output logic              fetchGloPred,
  output logic              fetchUseGlo,
  output logic [HIST_W-1:0] fetchHist,
  output logic              updLocPred,
  output logic              updGloPred
);

  localparam int LOC_N = 1 << LOC_IDX_W;
  localparam int GLO_N = 1 << HIST_W;
  localparam int SEL_N = 1 << SEL_IDX_W;

  ctr2_t locTab [LOC_N];
  ctr2_t gloTab [GLO_N];
  ctr2_t selTab [SEL_N];
  logic [HIST_W-1:0] histReg;

  logic [LOC_IDX_W-1:0] fLocIdx, uLocIdx;
  logic [SEL_IDX_W-1:0] fSelIdx, uSelIdx;

  always_comb begin
    fLocIdx      = fetchPc[LOC_IDX_W-1:0];
    fSelIdx      = fetchPc[SEL_IDX_W-1:0];
    uLocIdx      = updPc[LOC_IDX_W-1:0];
    uSelIdx      = updPc[SEL_IDX_W-1:0];
    fetchHist    = histReg;
    fetchLocPred = ctrTaken(locTab[fLocIdx]);
    fetchGloPred = ctrTaken(gloTab[histReg]);
    fetchUseGlo  = selTab[fSelIdx][1];
    updLocPred   = ctrTaken(locTab[uLocIdx]);
    updGloPred   = ctrTaken(gloTab[updHist]);
  end

  // local component
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LOC_N; i++) locTab[i] <= CTR_WEAK_NT;
    end else if (strobes.train) begin
      locTab[uLocIdx] <= satStep(locTab[uLocIdx], strobes.dirTaken);
    end
  end

  // global component
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < GLO_N; i++) gloTab[i] <= CTR_WEAK_NT;
    end else if (strobes.train) begin
      gloTab[updHist] <= satStep(gloTab[updHist], strobes.dirTaken);
    end
  end

  // chooser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SEL_N; i++) selTab[i] <= CTR_WEAK_LOCAL;
    end else if (strobes.selInc || strobes.selDec) begin
      selTab[uSelIdx] <= satStep(selTab[uSelIdx], strobes.selInc);
    end
  end

  // outcome history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              histReg <= '0;
    else if (strobes.train) histReg <= {histReg[HIST_W-2:0], strobes.dirTaken};
  end

  p_hist_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.train |=> $stable(histReg));

  p_hist_newest_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.train |=> (histReg[0] == $past(strobes.dirTaken)));

  p_loc_top_sat_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.train && strobes.dirTaken && locTab[uLocIdx] == CTR_MAX)
      |=> (locTab[$past(uLocIdx)] == CTR_MAX));

  p_loc_bot_sat_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.train && !strobes.dirTaken && locTab[uLocIdx] == CTR_MIN)
      |=> (locTab[$past(uLocIdx)] == CTR_MIN));

  p_sel_one_way_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.selInc && strobes.selDec));

endmodule

// File: rtl/tourney_bpred.sv
module tourney_bpred
  import tbp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int LOC_IDX_W = 8,
  parameter int HIST_W    = 8,
  parameter int SEL_IDX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   fetchPc,
  output logic              fetchTaken,
  output logic              fetchGlobalPred,
  output logic              fetchLocalPred,
  output logic              fetchUseGlobal,
  output logic [HIST_W-1:0] fetchHist,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic [HIST_W-1:0] updHist,
  input  logic              updTaken
);

  ctrlStrobes_t strobes;
  logic updLocPred, updGloPred;

  tbp_datapath #(
    .PC_W(PC_W), .LOC_IDX_W(LOC_IDX_W), .HIST_W(HIST_W), .SEL_IDX_W(SEL_IDX_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .updPc(updPc), .updHist(updHist),
    .strobes(strobes), .fetchLocPred(fetchLocalPred), .fetchGloPred(fetchGlobalPred),
    .fetchUseGlo(fetchUseGlobal), .fetchHist(fetchHist),
    .updLocPred(updLocPred), .updGloPred(updGloPred)
  );

  tbp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updTaken(updTaken),
    .updGloPred(updGloPred), .updLocPred(updLocPred), .strobes(strobes)
  );

  assign fetchTaken = fetchUseGlobal ? fetchGlobalPred : fetchLocalPred;

  // R5: the final prediction always agrees with one of the two components
  p_final_from_component_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fetchTaken == fetchGlobalPred) || (fetchTaken == fetchLocalPred));

endmodule

// File: tb/test_tourney_bpred.sv
module test_tourney_bpred;

  localparam int PW = 8;
  localparam int IW = 3;
  localparam int N  = 1 << IW;

  logic clk = 0;
  logic rstN = 0;
  logic [PW-1:0] fetchPc = '0;
  logic fetchTaken, fetchGlobalPred, fetchLocalPred, fetchUseGlobal;
  logic [IW-1:0] fetchHist;
  logic updValid = 0;
  logic [PW-1:0] updPc = '0;
  logic [IW-1:0] updHist = '0;
  logic updTaken = 0;

  int checks = 0;
  int errors = 0;
  int lc [N];
  int gc [N];
  int sc [N];
  int hist;
  logic [7:0] lfsr = 8'hA5;

  always #10 clk = ~clk;

  tourney_bpred #(.PC_W(PW), .LOC_IDX_W(IW), .HIST_W(IW), .SEL_IDX_W(IW)) i_tourney_bpred (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .fetchTaken(fetchTaken),
    .fetchGlobalPred(fetchGlobalPred), .fetchLocalPred(fetchLocalPred),
    .fetchUseGlobal(fetchUseGlobal), .fetchHist(fetchHist),
    .updValid(updValid), .updPc(updPc), .updHist(updHist), .updTaken(updTaken)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int c, input bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic sweep();
    for (int p = 0; p < 2 * N; p++) begin
      int li;
      int expL, expG, expU;
      fetchPc = PW'(p);
      #1;
      li   = p % N;
      expL = (lc[li] >= 2) ? 1 : 0;
      expG = (gc[hist] >= 2) ? 1 : 0;
      expU = (sc[li] >= 2) ? 1 : 0;
      chk("R3 R2 local prediction", int'(fetchLocalPred), expL);
      chk("R4 R7 global prediction", int'(fetchGlobalPred), expG);
      chk("R6 chooser select", int'(fetchUseGlobal), expU);
      chk("R5 R9 final prediction", int'(fetchTaken), expU ? expG : expL);
      chk("R4 history", int'(fetchHist), hist);
    end
  endtask

  task automatic resolve(input int pc, input bit t);
    int li;
    bit lp, gp;
    @(negedge clk);
    updValid = 1;
    updPc    = PW'(pc);
    updHist  = IW'(hist);
    updTaken = t;
    @(posedge clk);
    #1;
    updValid = 0;
    li = pc % N;
    lp = (lc[li] >= 2);
    gp = (gc[hist] >= 2);
    if (gp == t && lp != t) sc[li] = sat(sc[li], 1);
    if (lp == t && gp != t) sc[li] = sat(sc[li], 0);
    lc[li]   = sat(lc[li], t);
    gc[hist] = sat(gc[hist], t);
    hist     = ((hist << 1) | int'(t)) % N;
    sweep();
  endtask

  task automatic idle(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      updValid = 0;
      updPc    = ~updPc;
      updHist  = ~updHist;
      updTaken = ~updTaken;
    end
    @(negedge clk);
    sweep();   // R8: state unchanged after scrambled idle inputs
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      lc[i] = 1; gc[i] = 1; sc[i] = 1;
    end
    hist = 0;
    #5;
    // R1: reset state visible while reset held
    chk("R1 reset final", int'(fetchTaken), 0);
    chk("R1 reset chooser", int'(fetchUseGlobal), 0);
    chk("R1 reset history", int'(fetchHist), 0);
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    sweep();

    // R2: saturation at both ends on one entry
    for (int k = 0; k < 6; k++) resolve(2, 1);
    for (int k = 0; k < 6; k++) resolve(2, 0);
    idle(4);

    // R6 R7: alternating pattern favours the history-indexed component
    for (int k = 0; k < 24; k++) resolve(5, k[0]);
    idle(3);

    // R3: aliasing through the upper address bits
    for (int k = 0; k < 8; k++) resolve(8 + 3, 1);

    // pseudo-random stream with idle gaps
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      resolve(int'(lfsr[3:0]), lfsr[6] ^ lfsr[1]);
      if (k % 25 == 24) idle(2);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule